// File: doc/BRIEF.md
# Error-Feedback Word-Length Reduction Shaper

This block shortens signed PCM audio samples (20 bits to 16 bits by default) at the base sample rate, with no oversampling. The samples themselves pass through no filter. Only the requantization error is shaped. Each output word is formed by rounding a corrected sample. The error made by that rounding is stored. Over the next few samples, a short FIR over those stored errors is subtracted from the incoming data. The effect is to move requantization noise from one part of the audio band to another.

An optional triangular-density dither can be added in front of the rounding step so that the error becomes white. It is built from two pseudo-random uniform values, each spanning one output LSB. A single input turns the dither off. The samples arrive as a valid-qualified stream. The reduced word leaves one clock later together with its valid flag. The filter coefficients are fixed by parameters.

Top module: `ns_wordlen_shaper`

## Requirements
- R1: For each valid sample, the corrected value is q = x - fb + d, with x the signed input, fb the feedback and d the dither. The output is floor((q + 2^(SH-1)) / 2^SH), where SH = IN_W - OUT_W, so exact halves round upward.
- R2: The rounded value saturates at the signed OUT_W limits -2^(OUT_W-1) and 2^(OUT_W-1)-1.
- R3: The stored error is e = y*2^SH - q, computed with the saturated output y. It is clamped to the range [-2^(SH+1), +2^(SH+1)].
- R4: fb = floor(sum over k of C_k * e[n-1-k] / 2^COEF_FRAC) for k below NTAPS. C_k is a signed COEF_W-bit coefficient with COEF_FRAC fraction bits. With all coefficients zero, the output is plain rounding of x.
- R5: The error history advances only on valid samples. Cycles without valid leave the sequence of output words unchanged.
- R6: out_valid equals in_valid delayed by one clock. out_data changes only after a valid sample and holds otherwise.
- R7: With dither enabled, d = ua + ub - 2^SH. Each of ua and ub is the low SH bits of its own 16-bit LFSR, and both LFSRs step once per valid sample. This puts d in [-2^SH, 2^SH-2], so the output lies between the R1/R2 results for x - 2^SH and x + 2^SH - 2. Over many samples, some outputs differ from undithered rounding.
- R8: When dither_off is 1, d is zero and the output follows R1 to R4 exactly.
- R9: While rst_n is low at a clock edge, out_valid and out_data become 0 and the error history clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | IN_W | Signed input sample |
| dither_off | input | 1 | 1 forces the dither to zero |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | OUT_W | Signed reduced sample |

## Verification
The bench builds two instances that reduce 8 bits to 4 bits, so SH is 4 and every one of the 256 input codes can be swept.

One instance uses a second-order error filter with coefficients 2.0 and -1.0 in Q3.6. With this filter, rounding, saturation, error clamping and history under valid gaps can all be predicted by integer arithmetic. The other instance has a single zero tap. It exposes plain rounding and saturation over the whole input range, and it shows the dither bounds sample by sample. Runs of full-scale input drive the shaping instance into saturation, so the error clamp is exercised repeatedly.

// File: rtl/nsq_pkg.sv
// Package: shared helpers for the word-length reduction shaper.
// Assumes 16-bit pseudo-random generators are wide enough for the dither.
package nsq_pkg;
    localparam int RNG_W = 16;

    // Galois step of a maximal-length 16-bit generator
    function automatic logic [RNG_W-1:0] rng_next(input logic [RNG_W-1:0] s);
        return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
    endfunction
endpackage

// File: rtl/nsq_tpdf_dither.sv
// Module: triangular-density dither source. Sums two uniform values, each
// spanning one output LSB (2^SH input codes), and re-centres the sum.
// Assumes 1 <= SH <= 16 and nonzero seeds; steps only when adv is high.
module nsq_tpdf_dither #(
    parameter int SH     = 4,
    parameter int SEED_A = 16'hACE1,
    parameter int SEED_B = 16'h1D2B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 off,
    output logic signed [SH+1:0] d
);
    import nsq_pkg::*;
    localparam int DW = SH + 2;

    logic [RNG_W-1:0] s_a, s_b;
    logic [DW-1:0]    ua, ub;

    // Two generators stepping once per accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_a <= RNG_W'(SEED_A);
            s_b <= RNG_W'(SEED_B);
        end else if (adv) begin
            s_a <= rng_next(s_a);
            s_b <= rng_next(s_b);
        end
    end

    // Sum of two uniforms minus the offset; forced to zero when disabled
    always_comb begin
        ua = DW'(s_a[SH-1:0]);
        ub = DW'(s_b[SH-1:0]);
        d  = off ? '0 : $signed(ua + ub - DW'(1 << SH));
    end
endmodule

// File: rtl/nsq_round_sat.sv
// Module: rounding quantizer. Rounds the corrected value to the nearest
// output level (halves upward), saturates to the output range and produces
// the clamped error between the saturated output and the quantizer input.
// Assumes QW >= OUT_W + SH and SH >= 1.
module nsq_round_sat #(
    parameter int QW    = 24,
    parameter int SH    = 4,
    parameter int OUT_W = 16,
    parameter int EW    = 7
) (
    input  logic signed [QW-1:0]    q_in,
    output logic signed [OUT_W-1:0] y,
    output logic signed [EW-1:0]    err
);
    localparam logic signed [QW:0]   HALF = (QW+1)'(1 << (SH-1));
    localparam logic signed [QW:0]   MAXV = (QW+1)'((1 << (OUT_W-1)) - 1);
    localparam logic signed [QW:0]   MINV = -(QW+1)'(1 << (OUT_W-1));
    localparam logic signed [QW+1:0] ELIM = (QW+2)'(1 << (SH+1));

    logic signed [QW:0]   sum, r;
    logic signed [QW+1:0] ysc, diff;

    // Round half up, then clip to the output range
    always_comb begin
        sum = (QW+1)'(q_in) + HALF;
        r   = sum >>> SH;
        if (r > MAXV)      y = OUT_W'(MAXV);
        else if (r < MINV) y = OUT_W'(MINV);
        else               y = OUT_W'(r);
    end

    // Error of the saturated output, limited to keep the loop bounded
    always_comb begin
        ysc  = (QW+2)'(y) <<< SH;
        diff = ysc - (QW+2)'(q_in);
        if (diff > ELIM)       err = EW'(ELIM);
        else if (diff < -ELIM) err = EW'(-ELIM);
        else                   err = EW'(diff);
    end
endmodule

// File: rtl/nsq_err_fir.sv
// Module: error filter. Holds the last NTAPS quantizer errors and forms the
// fixed-point weighted sum, floored by COEF_FRAC fraction bits.
// Assumes 1 <= NTAPS <= 4; history moves only when adv is high.
module nsq_err_fir #(
    parameter int NTAPS     = 2,
    parameter int COEF_W    = 10,
    parameter int COEF_FRAC = 6,
    parameter int EW        = 7,
    parameter int FBW       = 19,
    parameter int EL        = 32,
    parameter int C0        = 128,
    parameter int C1        = -64,
    parameter int C2        = 0,
    parameter int C3        = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv,
    input  logic signed [EW-1:0]  err_in,
    output logic signed [FBW-1:0] fb
);
    localparam int PW = EW + COEF_W;
    localparam logic signed [COEF_W-1:0] CF [4] =
        '{COEF_W'(C0), COEF_W'(C1), COEF_W'(C2), COEF_W'(C3)};

    logic signed [EW-1:0]  hist [NTAPS];
    logic signed [PW-1:0]  prod [NTAPS];
    logic signed [FBW-1:0] acc;

    // Error history: newest in slot 0, shifted on each accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAPS; k++) hist[k] <= '0;
        end else if (adv) begin
            hist[0] <= err_in;
            for (int k = 1; k < NTAPS; k++) hist[k] <= hist[k-1];
        end
    end

    // One product per tap
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        always_comb prod[k] = hist[k] * CF[k];
    end

    // Sum of products, then floor by the coefficient fraction
    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAPS; k++) acc = acc + FBW'(prod[k]);
        fb = acc >>> COEF_FRAC;
    end

    // R5: history is frozen on cycles without a valid sample
    a_r5_hist_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(hist[0]) && $stable(hist[NTAPS-1]));

    // R3: stored error never exceeds the clamp limit
    a_r3_err_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (hist[0] <= EL) && (hist[0] >= -EL));
endmodule

// File: rtl/ns_wordlen_shaper.sv
// Module: top of the error-feedback word-length reducer. Subtracts the
// filtered past error from the input, adds optional dither, rounds and
// saturates, and registers the result with one cycle of latency.
// Assumes IN_W > OUT_W and a synchronous active-low reset.
module ns_wordlen_shaper #(
    parameter int IN_W      = 20,
    parameter int OUT_W     = 16,
    parameter int NTAPS     = 2,
    parameter int COEF_W    = 10,
    parameter int COEF_FRAC = 6,
    parameter int C0        = 128,
    parameter int C1        = -64,
    parameter int C2        = 0,
    parameter int C3        = 0,
    parameter int SEED_A    = 16'hACE1,
    parameter int SEED_B    = 16'h1D2B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic             dither_off,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    localparam int SH   = IN_W - OUT_W;
    localparam int EW   = SH + 3;
    localparam int ELIM = 1 << (SH + 1);
    localparam int FBW  = COEF_W + EW + 2;
    localparam int QW   = ((FBW > IN_W) ? FBW : IN_W) + 2;

    logic signed [SH+1:0]    d;
    logic signed [FBW-1:0]   fb;
    logic signed [QW-1:0]    q_in;
    logic signed [OUT_W-1:0] y;
    logic signed [EW-1:0]    err;

    nsq_tpdf_dither #(.SH(SH), .SEED_A(SEED_A), .SEED_B(SEED_B)) u_dither (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .off(dither_off), .d(d));

    nsq_err_fir #(.NTAPS(NTAPS), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
                  .EW(EW), .FBW(FBW), .EL(ELIM),
                  .C0(C0), .C1(C1), .C2(C2), .C3(C3)) u_fir (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .err_in(err), .fb(fb));

    nsq_round_sat #(.QW(QW), .SH(SH), .OUT_W(OUT_W), .EW(EW)) u_q (
        .q_in(q_in), .y(y), .err(err));

    // Corrected quantizer input: sample minus feedback plus dither
    always_comb q_in = QW'($signed(in_data)) - QW'(fb) + QW'(d);

    // Output register with valid passed alongside
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= y;
        end
    end

    // R6: valid appears one cycle after an accepted sample
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R6: no output valid without an input one cycle earlier
    a_r6_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R6: data holds across idle cycles
    a_r6_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    // R9: reset clears the output
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !out_valid && (out_data == '0));
endmodule

// File: tb/ns_wordlen_shaper_tb_top.sv
// Bench: 8-to-4 bit reduction; shaping instance (taps 2.0, -1.0) and a
// zero-tap instance, checked against integer arithmetic from the brief.
module ns_wordlen_shaper_tb_top;
    localparam int IW = 8;
    localparam int OW = 4;
    localparam int SH = IW - OW;
    localparam int EL = 1 << (SH + 1);

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic [IW-1:0] in_data = '0;
    logic dither_off = 1;
    logic ov_i, ov_z;
    logic [OW-1:0] od_i, od_z;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int e1 = 0, e2 = 0;
    int prev_i = 0, prev_z = 0;
    int dith_diff = 0;

    always #2.5 clk = ~clk;

    ns_wordlen_shaper #(.IN_W(IW), .OUT_W(OW), .NTAPS(2), .COEF_W(10),
        .COEF_FRAC(6), .C0(128), .C1(-64)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .dither_off(dither_off), .out_valid(ov_i), .out_data(od_i));

    ns_wordlen_shaper #(.IN_W(IW), .OUT_W(OW), .NTAPS(1), .COEF_W(10),
        .COEF_FRAC(6), .C0(0)) dut_z (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .dither_off(dither_off), .out_valid(ov_z), .out_data(od_z));

    function automatic int rnd_sat(input int q);
        int r;
        r = (q + (1 << (SH-1))) >>> SH;
        if (r > (1 << (OW-1)) - 1) r = (1 << (OW-1)) - 1;
        if (r < -(1 << (OW-1))) r = -(1 << (OW-1));
        return r;
    endfunction

    function automatic int sx(input logic [OW-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, check just after the rising edge
    task automatic step(input int x, input bit v, input bit doff, input string tag);
        int fb, q, yi, yz, err, lo, hi;
        @(negedge clk);
        in_valid = v; in_data = IW'(x); dither_off = doff;
        fb = (128 * e1 - 64 * e2) >>> 6;
        q  = x - fb;
        yi = rnd_sat(q);
        yz = rnd_sat(x);
        @(posedge clk); #1;
        check(ov_i == v && ov_z == v, "R6 valid latency", int'(ov_i), int'(v));
        if (!v) begin
            check(sx(od_i) == prev_i, "R6/R5 hold shaped", sx(od_i), prev_i);
            check(sx(od_z) == prev_z, "R6 hold plain", sx(od_z), prev_z);
        end else if (doff) begin
            check(sx(od_z) == yz, {tag, " plain"}, sx(od_z), yz);
            check(sx(od_i) == yi, {tag, " shaped R4 R8"}, sx(od_i), yi);
            err = yi * (1 << SH) - q;
            if (err > EL) err = EL;
            if (err < -EL) err = -EL;
            e2 = e1; e1 = err;
            prev_i = yi; prev_z = yz;
        end else begin
            lo = rnd_sat(x - (1 << SH));
            hi = rnd_sat(x + (1 << SH) - 2);
            check(sx(od_z) >= lo && sx(od_z) <= hi, "R7 dither bound", sx(od_z), lo);
            if (sx(od_z) != yz) dith_diff++;
            prev_i = sx(od_i); prev_z = sx(od_z);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; in_valid = 0;
        repeat (3) @(posedge clk);
        #1;
        check(ov_i == 0 && ov_z == 0, "R9 reset valid", int'(ov_i | ov_z), 0);
        check(od_i == 0 && od_z == 0, "R9 reset data", sx(od_i), 0);
        @(negedge clk); rst_n = 1;
        e1 = 0; e2 = 0; prev_i = 0; prev_z = 0;
    endtask

    initial begin
        do_reset();
        // R1 R2: full sweep of every input code, dither off
        for (int x = -128; x < 128; x++)
            step(x, 1, 1, (x > 119 || x < -128) ? "R2 saturate" : "R1 round");
        check(sx(od_z) == 7, "R2 top code", sx(od_z), 7);
        // R3: full-scale runs push error into the clamp
        for (int k = 0; k < 20; k++) step(127, 1, 1, "R3 clamp high");
        for (int k = 0; k < 20; k++) step(-128, 1, 1, "R3 clamp low");
        // R5 R6: valid gaps with a varying signal
        for (int k = 0; k < 300; k++)
            step(((k * 37) % 256) - 128, (k % 3) != 0, 1, "R5 gapped");
        // R4: slow ramp and small constants
        for (int k = 0; k < 200; k++) step((k % 40) - 20, 1, 1, "R4 ramp");
        for (int k = 0; k < 50; k++) step(3, 1, 1, "R4 constant");
        // R7: dither enabled, bounds per sample
        for (int k = 0; k < 512; k++) step(((k * 11) % 200) - 100, 1, 0, "R7");
        check(dith_diff > 0, "R7 dither active", dith_diff, 1);
        // R8: back to exact behaviour after reset with dither off
        do_reset();
        for (int k = 0; k < 100; k++) step(((k * 53) % 256) - 128, 1, 1, "R8 exact");
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk); cyc++;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule